// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate-Subtract Unit

This block holds a 64-bit accumulator as two 32-bit registers: a high half and a low half. A single command port drives it. Each command carries an opcode and two 32-bit operands. The block can do four things with them:

- form a signed product that overwrites the accumulator;
- add the product to the accumulator;
- subtract the product from the accumulator;
- load either half directly from the first operand.

The result is registered at the clock edge that samples the command. From the next cycle on, both halves are visible on the read ports.

The subtract direction is the point of this block. The product is taken away from the accumulator, never the other way round. Both operands are sign-extended to 64 bits before they are multiplied. The two halves are joined unsigned, with the high half in the upper 32 bits. All arithmetic wraps modulo 2^64.

Top module: `hilo_macc_unit`

## Requirements
- R1: After reset, both `hi_q` and `lo_q` are zero.
- R2: Opcode 3'd0 (multiply) with `cmd_valid` high replaces the accumulator with the signed 64-bit product of `rs` and `rt`. Bits 63..32 of the product go to `hi_q` and bits 31..0 go to `lo_q`.
- R3: Opcode 3'd1 (multiply-add) sets `{hi_q,lo_q}` to the old `{hi_q,lo_q}` plus the signed product.
- R4: Opcode 3'd2 (multiply-subtract) sets `{hi_q,lo_q}` to the old `{hi_q,lo_q}` minus the signed product. With HI=0, LO=2 and a zero product, the result stays HI=0, LO=2.
- R5: Opcode 3'd3 loads `lo_q` from `rs` and leaves `hi_q` unchanged.
- R6: Opcode 3'd4 loads `hi_q` from `rs` and leaves `lo_q` unchanged.
- R7: Addition and subtraction wrap modulo 2^64, and no flag is raised.
- R8: A cycle with `cmd_valid` low, or with an opcode of 3'd5, 3'd6 or 3'd7, leaves both halves unchanged.
- R9: A command sampled at one rising edge is visible on `hi_q`/`lo_q` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode |
| rs | input | 32 | First operand (signed) |
| rt | input | 32 | Second operand (signed) |
| hi_q | output | 32 | Registered high half of the accumulator |
| lo_q | output | 32 | Registered low half of the accumulator |

## Verification
The assertions are checked on every cycle:

- the hold behaviour on idle and reserved opcodes;
- the move commands, including the half they must leave alone;
- the multiply;
- the subtract direction, checked by adding the old product back to the new accumulator and comparing with the old accumulator.

Only the bench scenarios can show the following:

- that the reset value is zero;
- the exact 0/2 case that exposes a reversed subtraction;
- wraparound across the 64-bit boundary in both directions;
- the extreme operand case where the most negative value is squared.

// File: rtl/hilo_macc_unit.sv
module hilo_macc_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] rs,
  input  logic [W-1:0] rt,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  localparam int AW = 2 * W;
  localparam logic [2:0] OP_MUL  = 3'd0;
  localparam logic [2:0] OP_MADD = 3'd1;
  localparam logic [2:0] OP_MSUB = 3'd2;
  localparam logic [2:0] OP_TOLO = 3'd3;
  localparam logic [2:0] OP_TOHI = 3'd4;

  logic signed [AW-1:0] rs_x, rt_x, prod;
  logic [AW-1:0] acc, acc_nxt;

  assign rs_x = {{W{rs[W-1]}}, rs};
  assign rt_x = {{W{rt[W-1]}}, rt};
  assign prod = rs_x * rt_x;
  assign acc  = {hi_q, lo_q};

  always_comb begin
    acc_nxt = acc;
    if (cmd_valid) begin
      case (cmd_op)
        OP_MUL:  acc_nxt = prod;
        OP_MADD: acc_nxt = acc + prod;
        OP_MSUB: acc_nxt = acc - prod;
        OP_TOLO: acc_nxt = {hi_q, rs};
        OP_TOHI: acc_nxt = {rs, lo_q};
        default: acc_nxt = acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= acc_nxt[AW-1:W];
      lo_q <= acc_nxt[W-1:0];
    end
  end
endmodule

// File: rtl/hilo_macc_checks.sv
module hilo_macc_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [W-1:0] rs,
  input logic [W-1:0] rt,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  logic signed [2*W-1:0] p;
  assign p = $signed({{W{rs[W-1]}}, rs}) * $signed({{W{rt[W-1]}}, rt});

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op > 3'd4) |=> ($stable(hi_q) && $stable(lo_q)));

  p_tolo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=> (lo_q == $past(rs) && hi_q == $past(hi_q)));

  p_tohi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> (hi_q == $past(rs) && lo_q == $past(lo_q)));

  p_mul_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> ({hi_q, lo_q} == $past(p)));

  p_sub_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2) |=> (({hi_q, lo_q} + $past(p)) == $past({hi_q, lo_q})));

  p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> (({hi_q, lo_q} - $past(p)) == $past({hi_q, lo_q})));
endmodule

bind hilo_macc_unit hilo_macc_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rs(rs), .rt(rt), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/tb_hilo_macc_unit.sv
module tb_hilo_macc_unit;
  logic clk = 0;
  logic rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [31:0] rs = 0, rt = 0;
  logic [31:0] hi_q, lo_q;

  int checks = 0, errors = 0;
  logic [63:0] model = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  hilo_macc_unit dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
                      .rs(rs), .rt(rt), .hi_q(hi_q), .lo_q(lo_q));

  function automatic logic [63:0] sprod(logic [31:0] a, logic [31:0] b);
    logic signed [63:0] ax, bx;
    ax = {{32{a[31]}}, a};
    bx = {{32{b[31]}}, b};
    return ax * bx;
  endfunction

  // driver: drive at negedge, update model, push expected after the edge
  task automatic issue(input bit v, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; rs = a; rt = b;
    if (v) begin
      case (op)
        3'd0: model = sprod(a, b);
        3'd1: model = model + sprod(a, b);
        3'd2: model = model - sprod(a, b);
        3'd3: model = {model[63:32], a};
        3'd4: model = {a, model[31:0]};
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({hi_q, lo_q} !== e) begin
        errors++;
        $display("FAIL %s: got %h_%h expected %h_%h", t, hi_q, lo_q, e[63:32], e[31:0]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    issue(0, 3'd0, 0, 0, "R1");                            // reset value
    issue(1, 3'd0, 32'd3, 32'hFFFF_FFFC, "R2");            // 3 * -4
    issue(1, 3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R2");
    issue(1, 3'd0, 32'h8000_0000, 32'h8000_0000, "R2");    // most negative squared
    issue(1, 3'd3, 32'd2, 0, "R5");                        // hi keeps old value
    issue(1, 3'd4, 32'd0, 0, "R6");
    issue(1, 3'd2, 32'd0, 32'd5, "R4");                    // 0/2 must stay 0/2
    issue(1, 3'd3, 32'd100, 0, "R5");
    issue(1, 3'd2, 32'd3, 32'd4, "R4");                    // 100 - 12
    issue(1, 3'd2, 32'd10, 32'd10, "R4");                  // below zero
    issue(1, 3'd1, 32'hFFFF_FFFF, 32'd7, "R3");            // add a negative product
    issue(1, 3'd1, 32'd50, 32'd3, "R3");
    issue(1, 3'd4, 32'hFFFF_FFFF, 0, "R6");
    issue(1, 3'd3, 32'hFFFF_FFFF, 0, "R5");
    issue(1, 3'd1, 32'd1, 32'd1, "R7");                    // wraps to zero
    issue(1, 3'd2, 32'd1, 32'd1, "R7");                    // wraps to all ones
    issue(1, 3'd4, 32'h1234_5678, 0, "R9");
    issue(0, 3'd2, 32'd9, 32'd9, "R8");                    // strobe low
    issue(1, 3'd5, 32'd9, 32'd9, "R8");
    issue(1, 3'd6, 32'd9, 32'd9, "R8");
    issue(1, 3'd7, 32'd9, 32'd9, "R8");
    issue(1, 3'd2, 32'hFFFF_FFFE, 32'd3, "R4");            // minus a negative product
    issue(0, 3'd0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results never compared, expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9: watchdog expired, got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule